// File: doc/BRIEF.md
# Clock Generator Serial Control Slave

This block is the configuration front end of a multi-output clock generator. It is a two-wire serial slave in the block-write style. Once a master has addressed it, the master sends two bytes, a command byte and a count byte. The slave acknowledges both and discards their contents. Every data byte after them is written to register 0, then register 1, and so on in order. The write pointer returns to register 0 at each STOP condition.

A read transaction returns the registers in the same order, starting at register 0. The slave stops sending when the master answers a byte with NACK. Some read-back bits report the inverted levels of the strap pins. Two registers are fixed identification values.

The register outputs drive the generator directly:
- stop bits for each output group;
- a global tristate control;
- the spread-spectrum enable and depth;
- an SDRAM-to-CPU skew code;
- a 6-bit frequency-select code.

The frequency-select code comes from one of two sources. With the mode bit clear, it is the 5-bit hardware strap value, padded with a leading zero. With the mode bit set, it is six software bits. The strap pins double as clock outputs after power-up, so the block samples them once, when reset is released, and keeps the sampled values in flops.

Top module: `clkgen_ctrl_slave`

## Requirements
- R1: After reset the register contents are as follows.
  - Register 0 is 0x00.
  - The writable bits of register 1 are 0x1E.
  - Registers 2 and 3 are 0xFF.
  - The writable bits of register 4 are 0x6B.
  - Register 5 is 0x90.
  - So at the ports: all enables are 1, tristate is 0, spread enable is 0, spread depth select is 1, skew is 3'b100, and the free-running memory clock enable is 1.
- R2: Only address byte {DEV_ADDR, rw} (default DEV_ADDR 7'h69) is acknowledged. Any other address gets no ACK and changes nothing.
- R3: The first two bytes after a write address are acknowledged and have no effect. The third byte is the first data byte and lands in register 0.
- R4: The data bytes of one write transaction go to consecutive registers starting at 0. Each data byte is acknowledged.
- R5: Writes to read-only bits, to registers 6 and 7, and to pointers above 7 are acknowledged and discarded. The read-only bits are register 1 bits 7:5, register 4 bits 7, 4 and 2, register 5 bits 3:0, and all of registers 6 and 7.
- R6: A STOP resets the register pointer. The next transaction starts at register 0.
- R7: The frequency code depends on register 0 bit 3.
  - If the bit is 0, the code is {1'b0, strap_fs_i as latched}.
  - If the bit is 1, the code is {reg0[1], reg0[2], reg0[7:4]}.
- R8: tristate_o follows register 0 bit 0.
- R9: The strap inputs are sampled once after reset is released. Later changes on the strap pins have no effect until the next reset.
- R10: A read returns the registers in order from register 0.
  - Register 1 reads {~fs[3], ~fs[0], ~fs[2], reg1[4:0]}.
  - Register 4 reads {~iodiv, reg4[6:5], ~fs[4], reg4[3], ~fs[1], reg4[1:0]}.
  - Registers 6 and 7 read 0x98 and 0x21.
  - A master NACK ends the read.
- R11: Register 1 maps to outputs as follows: bit 0 is the spread enable, bit 1 is the spread depth select (1 selects the narrow 0.25% setting), and bits 4:2 are the fixed-clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial bus |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_fs_i | input | 5 | Hardware frequency strap pins |
| strap_iodiv_i | input | 1 | I/O clock divider strap pin |
| sel_code_o | output | 6 | Frequency table index |
| sw_sel_o | output | 1 | 1 when the software select bits are used |
| tristate_o | output | 1 | Tristate all clock outputs |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_narrow_o | output | 1 | Spread depth: 1 = 0.25%, 0 = 0.5% |
| fixed_en_o | output | 3 | Fixed-frequency clock enables |
| mem_en_o | output | 8 | Memory clock enables |
| memf_en_o | output | 1 | Free-running memory clock enable |
| bus_en_o | output | 8 | Bus clock enables |
| mid_en_o | output | 2 | Mid-rate clock enables |
| ioapic_en_o | output | 1 | Interrupt controller clock enable |
| cpu_en_o | output | 2 | Processor clock enables |
| skew_o | output | 3 | SDRAM-to-CPU skew code |
| iodiv_strap_o | output | 1 | Latched I/O divider strap level |

## Verification
The hardest state to reach from the ports is a long write that runs past the last writable register and then beyond register 7. It must leave the identification registers and the read-only strap bits untouched while every byte is still acknowledged. The bench sends ten data bytes in one transaction and then reads all eight registers back, after driving the strap pins to new levels. Any mismatch exposes a stray write or a re-sampled strap.

A second hard case is a pointer carried over between transactions. The bench writes two bytes, stops, writes one byte, and then checks that register 1 kept its value.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;
  localparam int NUM_REGS = 8;
  localparam int NUM_RW   = 6;
  localparam int PTR_W    = 4;
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};
  localparam logic [7:0] ID_LO = 8'h98;
  localparam logic [7:0] ID_HI = 8'h21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WR, ST_RD
  } bus_st_e;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h1E;
      2:       return 8'hFF;
      3:       return 8'hFF;
      4:       return 8'h6B;
      5:       return 8'h90;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'h1F;
      2:       return 8'hFF;
      3:       return 8'hFF;
      4:       return 8'h6B;
      5:       return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkgen_bus_sync.sv
module clkgen_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q[0] <= scl_i;
      sda_sync_q[0] <= sda_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_sync_q[i] <= scl_sync_q[i-1];
        sda_sync_q[i] <= sda_sync_q[i-1];
      end
      scl_d_q <= scl_sync_q[SYNC_STAGES-1];
      sda_d_q <= sda_sync_q[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  // data edges while the clock stays high
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/clkgen_bus_fsm.sv
module clkgen_bus_fsm
  import clkgen_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic [PTR_W-1:0] ptr_o
);
  bus_st_e          st_q;
  logic [7:0]       sr_q;
  logic [3:0]       bit_cnt_q;
  logic             ack_ph_q, rw_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;

  assign ptr_inc = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sr_q      <= '0;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      rw_q      <= 1'b0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        ptr_q    <= '0;
        ack_ph_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: ;
          ST_RD: begin
            if (!ack_ph_q) begin
              if (scl_rise_i) bit_cnt_q <= bit_cnt_q + 1'b1;
              else if (scl_fall_i) begin
                if (bit_cnt_q == 4'd8) begin
                  sda_oe_o  <= 1'b0;
                  ack_ph_q  <= 1'b1;
                  bit_cnt_q <= '0;
                end else begin
                  sr_q     <= {sr_q[6:0], 1'b0};
                  sda_oe_o <= ~sr_q[6];
                end
              end
            end else begin
              if (scl_rise_i && sda_i) st_q <= ST_IDLE;  // master NACK
              else if (scl_fall_i) begin
                ack_ph_q <= 1'b0;
                sr_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr_q    <= ptr_inc;
              end
            end
          end
          default: begin
            if (!ack_ph_q) begin
              if (scl_rise_i && bit_cnt_q != 4'd8) begin
                sr_q      <= {sr_q[6:0], sda_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
                bit_cnt_q <= '0;
                if (st_q == ST_ADDR && sr_q[7:1] != DEV_ADDR) begin
                  st_q <= ST_IDLE;
                end else begin
                  ack_ph_q <= 1'b1;
                  sda_oe_o <= 1'b1;
                  if (st_q == ST_ADDR) rw_q <= sr_q[0];
                  if (st_q == ST_WR) begin
                    wr_en_o   <= 1'b1;
                    wr_data_o <= sr_q;
                  end
                end
              end
            end else if (scl_fall_i) begin
              ack_ph_q <= 1'b0;
              sda_oe_o <= 1'b0;
              case (st_q)
                ST_ADDR: begin
                  if (rw_q) begin
                    st_q     <= ST_RD;
                    sr_q     <= rd_data_i;
                    sda_oe_o <= ~rd_data_i[7];
                    ptr_q    <= ptr_inc;
                  end else begin
                    st_q <= ST_CMD;
                  end
                end
                ST_CMD:  st_q  <= ST_CNT;
                ST_CNT:  st_q  <= ST_WR;
                default: ptr_q <= ptr_inc;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;

  // data line only moves while the clock is low
  p_oe_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) && !$past(start_i || stop_i) |-> !$past(scl_i));

  p_stop_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (ptr_o == '0));

  p_wr_data_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(st_q) == ST_WR);
endmodule

// File: rtl/clkgen_regfile.sv
module clkgen_regfile
  import clkgen_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  input  logic [4:0]       strap_fs_i,
  input  logic             strap_iodiv_i,
  output logic [5:0]       sel_code_o,
  output logic             sw_sel_o,
  output logic             tristate_o,
  output logic             ss_en_o,
  output logic             ss_narrow_o,
  output logic [2:0]       fixed_en_o,
  output logic [7:0]       mem_en_o,
  output logic             memf_en_o,
  output logic [7:0]       bus_en_o,
  output logic [1:0]       mid_en_o,
  output logic             ioapic_en_o,
  output logic [1:0]       cpu_en_o,
  output logic [2:0]       skew_o,
  output logic             iodiv_strap_o
);
  logic [NUM_RW-1:0][7:0] regs_q;
  logic [4:0] strap_q;
  logic       iodiv_q, strap_done_q;

  for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
    localparam logic [7:0] DEF  = reg_default(k);
    localparam logic [7:0] MASK = reg_wmask(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[k] <= DEF;
      else if (wr_en_i && addr_i == PTR_W'(k)) regs_q[k] <= wr_data_i & MASK;
    end
  end

  // strap pins become clock outputs later: capture once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= '0;
      iodiv_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_fs_i;
      iodiv_q      <= strap_iodiv_i;
      strap_done_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      4'd0:    rd_data_o = regs_q[0];
      4'd1:    rd_data_o = {~strap_q[3], ~strap_q[0], ~strap_q[2], regs_q[1][4:0]};
      4'd2:    rd_data_o = regs_q[2];
      4'd3:    rd_data_o = regs_q[3];
      4'd4:    rd_data_o = {~iodiv_q, regs_q[4][6:5], ~strap_q[4], regs_q[4][3],
                            ~strap_q[1], regs_q[4][1:0]};
      4'd5:    rd_data_o = regs_q[5];
      4'd6:    rd_data_o = ID_LO;
      4'd7:    rd_data_o = ID_HI;
      default: rd_data_o = 8'hFF;
    endcase
  end

  assign sw_sel_o      = regs_q[0][3];
  assign sel_code_o    = sw_sel_o ? {regs_q[0][1], regs_q[0][2], regs_q[0][7:4]}
                                  : {1'b0, strap_q};
  assign tristate_o    = regs_q[0][0];
  assign ss_en_o       = regs_q[1][0];
  assign ss_narrow_o   = regs_q[1][1];
  assign fixed_en_o    = regs_q[1][4:2];
  assign mem_en_o      = regs_q[2];
  assign bus_en_o      = regs_q[3];
  assign cpu_en_o      = regs_q[4][1:0];
  assign ioapic_en_o   = regs_q[4][3];
  assign mid_en_o      = {regs_q[4][5], regs_q[4][6]};
  assign skew_o        = regs_q[5][7:5];
  assign memf_en_o     = regs_q[5][4];
  assign iodiv_strap_o = iodiv_q;

  p_strap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q && $past(strap_done_q) |-> $stable(strap_q) && $stable(iodiv_q));

  p_oob_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i >= PTR_W'(NUM_RW)) |=> $stable(regs_q));
endmodule

// File: rtl/clkgen_ctrl_slave.sv
module clkgen_ctrl_slave
  import clkgen_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [4:0] strap_fs_i,
  input  logic       strap_iodiv_i,
  output logic [5:0] sel_code_o,
  output logic       sw_sel_o,
  output logic       tristate_o,
  output logic       ss_en_o,
  output logic       ss_narrow_o,
  output logic [2:0] fixed_en_o,
  output logic [7:0] mem_en_o,
  output logic       memf_en_o,
  output logic [7:0] bus_en_o,
  output logic [1:0] mid_en_o,
  output logic       ioapic_en_o,
  output logic [1:0] cpu_en_o,
  output logic [2:0] skew_o,
  output logic       iodiv_strap_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [7:0] wr_data, rd_data;
  logic [PTR_W-1:0] ptr;

  clkgen_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  clkgen_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .rd_data_i(rd_data),
    .sda_oe_o, .wr_en_o(wr_en), .wr_data_o(wr_data), .ptr_o(ptr)
  );

  clkgen_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(ptr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .strap_fs_i, .strap_iodiv_i,
    .sel_code_o, .sw_sel_o, .tristate_o, .ss_en_o, .ss_narrow_o, .fixed_en_o,
    .mem_en_o, .memf_en_o, .bus_en_o, .mid_en_o, .ioapic_en_o, .cpu_en_o,
    .skew_o, .iodiv_strap_o
  );
endmodule

// File: tb/sim_clkgen_ctrl_slave.sv
module sim_clkgen_ctrl_slave;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  logic [4:0] strap_fs = 5'b10110;
  logic strap_iodiv = 1'b1;
  logic [5:0] sel_code;
  logic sw_sel, tristate, ss_en, ss_narrow, memf_en, ioapic_en, iodiv_strap;
  logic [2:0] fixed_en, skew;
  logic [7:0] mem_en, bus_en;
  logic [1:0] mid_en, cpu_en;

  clkgen_ctrl_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_fs_i(strap_fs), .strap_iodiv_i(strap_iodiv), .sel_code_o(sel_code),
    .sw_sel_o(sw_sel), .tristate_o(tristate), .ss_en_o(ss_en), .ss_narrow_o(ss_narrow),
    .fixed_en_o(fixed_en), .mem_en_o(mem_en), .memf_en_o(memf_en), .bus_en_o(bus_en),
    .mid_en_o(mid_en), .ioapic_en_o(ioapic_en), .cpu_en_o(cpu_en), .skew_o(skew),
    .iodiv_strap_o(iodiv_strap)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [12];
  logic [7:0] rbuf [8];
  logic all_ack;

  // {data, 1'b0, tristate, sel_code}
  localparam logic [15:0] VEC [8] = '{
    16'h0016, 16'h0800, 16'hF80F, 16'hFE3F,
    16'h5B65, 16'h0D50, 16'hA156, 16'h0A20
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    ack = ~sda_bus;
    q();
    scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q();
      scl_m = 1'b1; q();
      b = {b[6:0], sda_bus};
      q();
      scl_m = 1'b0;
    end
    q();
    sda_m = ~m_ack; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic write_regs(input int n);
    logic a;
    all_ack = 1'b1;
    bus_start();
    send_byte(8'hD2, a); all_ack &= a;
    send_byte(8'hA5, a); all_ack &= a;  // command, ignored
    send_byte(8'h3C, a); all_ack &= a;  // count, ignored
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic read_regs(input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    chk("R10 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    do_reset();
    // R1 reset state, R9 strap latched
    chk("R1 mem_en", mem_en, 8'hFF);
    chk("R1 bus_en", bus_en, 8'hFF);
    chk("R1 tristate", tristate, 0);
    chk("R11 ss_en default", ss_en, 0);
    chk("R11 ss_narrow default", ss_narrow, 1);
    chk("R1 fixed_en", fixed_en, 3'b111);
    chk("R1 skew", skew, 3'b100);
    chk("R1 memf_en", memf_en, 1);
    chk("R1 cpu/ioapic/mid", {cpu_en, ioapic_en, mid_en}, 5'b11111);
    chk("R7 hw sel after reset", sel_code, 6'h16);
    chk("R9 iodiv strap", iodiv_strap, 1);

    read_regs(8);
    chk("R10 reg0", rbuf[0], 8'h00);
    chk("R10 reg1", rbuf[1], 8'hDE);
    chk("R10 reg2", rbuf[2], 8'hFF);
    chk("R10 reg3", rbuf[3], 8'hFF);
    chk("R10 reg4", rbuf[4], 8'h6B);
    chk("R10 reg5", rbuf[5], 8'h90);
    chk("R10 reg6 id", rbuf[6], 8'h98);
    chk("R10 reg7 id", rbuf[7], 8'h21);

    // R9 strap pins change later: no effect
    strap_fs = 5'b00001; strap_iodiv = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 strap ignored after latch", sel_code, 6'h16);

    // R2 foreign address
    bus_start();
    send_byte(8'h24, a);
    chk("R2 foreign address no ack", a, 0);
    send_byte(8'hFF, a);
    chk("R2 data after foreign address no ack", a, 0);
    bus_stop();
    chk("R2 foreign write no effect", {sw_sel, tristate}, 2'b00);

    // table: R3 R7 R8
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      write_regs(1);
      chk("R3 acks", all_ack, 1);
      chk("R7 sel_code", sel_code, VEC[v][5:0]);
      chk("R8 tristate", tristate, VEC[v][6]);
    end

    // R4 R5 long write past the end
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h3C; wbuf[3] = 8'hC3;
    wbuf[4] = 8'h00; wbuf[5] = 8'h6F; wbuf[6] = 8'h00; wbuf[7] = 8'h00;
    wbuf[8] = 8'h55; wbuf[9] = 8'hAA;
    write_regs(10);
    chk("R5 all bytes acked", all_ack, 1);
    chk("R4 mem_en", mem_en, 8'h3C);
    chk("R4 bus_en", bus_en, 8'hC3);
    chk("R4 cpu/ioapic/mid off", {cpu_en, ioapic_en, mid_en}, 5'b00000);
    chk("R11 ss_en on", ss_en, 1);
    chk("R4 skew/memf", {skew, memf_en}, 4'b0110);
    read_regs(8);
    chk("R5 reg1 ro bits", rbuf[1], 8'hDF);
    chk("R5 reg4 ro bits", rbuf[4], 8'h00);
    chk("R5 reg5 reserved", rbuf[5], 8'h60);
    chk("R5 reg6 id kept", rbuf[6], 8'h98);
    chk("R5 reg7 id kept", rbuf[7], 8'h21);

    // R6 pointer back to 0 after STOP, R11 mapping
    wbuf[0] = 8'h00; wbuf[1] = 8'h01;
    write_regs(2);
    wbuf[0] = 8'h02;
    write_regs(1);
    chk("R6 reg1 untouched: ss_en", ss_en, 1);
    chk("R11 ss_narrow 0.5pct", ss_narrow, 0);
    chk("R11 fixed_en off", fixed_en, 3'b000);
    chk("R6 second txn hit reg0", tristate, 0);
    read_regs(2);
    chk("R6 reg0 readback", rbuf[0], 8'h02);
    chk("R10 reg1 readback", rbuf[1], 8'hC1);

    // R1 R9 new reset samples new straps
    strap_fs = 5'b01001; strap_iodiv = 1'b0;
    do_reset();
    chk("R9 relatched strap", sel_code, 6'h09);
    chk("R9 iodiv relatched", iodiv_strap, 0);
    chk("R1 mem_en after reset", mem_en, 8'hFF);
    read_regs(5);
    chk("R10 reg1 inverted straps", rbuf[1], 8'h3E);
    chk("R10 reg4 inverted straps", rbuf[4], 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule